// File: doc/BRIEF.md
# CRC-Guarded Serial Command Port

This block terminates a synchronous serial command link from a host controller. Every transaction is a 32-bit frame shifted in MSB first while chip-select is low. The first 24 bits are a command payload of opcode byte, register address byte and data byte. The last 8 bits are a CRC-8 that the host computes over that payload. When chip-select rises, the block recomputes the CRC and decides whether the command may run. It then updates a small register file or prepares read data, which the host clocks out during the following frame.

A CRC mismatch drops the command and sets a sticky error flag. While the flag is set, writes are refused except to the status and general-configuration registers. Reads are still answered. Three enable bits decide what else the error does: it can force every channel back to analog input, raise an abort line for autonomous conversion, and raise an internal alert. Clearing the flag with a write-one to the status register restores every channel to its programmed mode.

The serial link has no valid/ready handshake and no back-pressure. The host sets the pace with the serial clock, and every frame is taken as soon as it closes. All serial inputs are sampled in the `clk` domain, so each serial clock phase must last at least three `clk` cycles.

Top module: `crc_cmd_if`

## Requirements
- R1: A 32-clock frame whose trailing byte differs from CRC-8 (polynomial 0x07, initial value 0xFF, payload MSB first) of its first 24 bits does not execute, and it sets `crc_err_o` to 1. The flag stays at 1 until it is cleared under R3, and it reads back as bit 0 of the status register (address 0x00).
- R2: While the error flag is 1, a valid write to the pin-mode register (0x02) or the output-enable register (0x03) leaves that register unchanged. Once the flag clears, such writes take effect again.
- R3: While the error flag is 1, valid writes to the general-configuration register (0x01) still take effect. A valid write to the status register with data bit 0 set clears the flag. A status write with bit 0 clear, or one that carries a bad CRC, leaves the flag at 1.
- R4: While the error flag is 1, read commands (opcode 0x08) with a valid CRC are still answered with the current register contents.
- R5: After a valid read frame, the next frame shifts out {0x08, address, read data, CRC-8 of those 24 bits} MSB first on `spi_sdo_o`. After any other 32-clock frame (a write, an unknown opcode or a bad CRC), the next frame shifts out all zeros.
- R6: When the error flag and configuration bit 0 (safe-channel enable) are both 1, `chan_digital_o` and `chan_drive_o` are all zero. Otherwise both outputs follow the registers, as given in R11.
- R7: `conv_abort_o` is 1 exactly when the error flag is 1 and configuration bit 1 (abort enable) is 1.
- R8: `alert_o` is 1 exactly when the error flag is 1 and configuration bit 2 (alert enable) is 1.
- R9: A frame that does not hold exactly 32 rising serial clocks is discarded. It leaves the registers, the error flag and the pending read response unchanged.
- R10: After reset, all registers and the error flag are zero, `spi_sdo_o` is 0 and every output is 0.
- R11: Outside the forced state, `chan_digital_o` equals the pin-mode register, and `chan_drive_o` equals pin-mode AND output-enable.
- R12: A read of address 0x04 returns `conv_data_i` as sampled when the read frame is evaluated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck_i | input | 1 | Serial clock; data is sampled on its rising edge |
| spi_cs_n_i | input | 1 | Active-low frame select; its rising edge closes a frame |
| spi_sdi_i | input | 1 | Serial data from the host, MSB first |
| spi_sdo_o | output | 1 | Serial data to the host; changes after a falling serial clock |
| conv_data_i | input | 8 | Latest conversion result, readable at address 0x04 |
| chan_digital_o | output | NCH | Per-channel digital-mode select (0 = analog input) |
| chan_drive_o | output | NCH | Per-channel output-driver enable |
| crc_err_o | output | 1 | Sticky CRC error flag |
| alert_o | output | 1 | Internal alert on CRC error |
| conv_abort_o | output | 1 | Abort request for autonomous conversion |

## Verification
The bench first locks the block with a corrupted write. It then tries blocked and whitelisted writes. A design that gates every write would miss the configuration change, and one that gates none would let the pin mode change. It sends a short frame and a 33-clock frame. A design that counts badly would either execute those frames or flag them as CRC errors, and would lose the pending read response that the next full frame must still carry. It also checks that clearing needs both bit 0 and a good CRC, that channels come back to their programmed modes once the flag clears, and that the alert, abort and safe-channel effects stay off when their enable bits are clear.

// File: rtl/crc_cmd_pkg.sv
package crc_cmd_pkg;
  localparam int FRAME_W = 32;
  localparam int CRC_W   = 8;
  localparam int PAY_W   = FRAME_W - CRC_W;
  localparam int BYTE_W  = 8;
  localparam int CNT_W   = $clog2(FRAME_W + 2);

  localparam logic [BYTE_W-1:0] OP_READ  = 8'h08;
  localparam logic [BYTE_W-1:0] OP_WRITE = 8'h10;

  localparam logic [BYTE_W-1:0] ADDR_STATUS  = 8'h00;
  localparam logic [BYTE_W-1:0] ADDR_GENCFG  = 8'h01;
  localparam logic [BYTE_W-1:0] ADDR_PINMODE = 8'h02;
  localparam logic [BYTE_W-1:0] ADDR_OUTEN   = 8'h03;
  localparam logic [BYTE_W-1:0] ADDR_CONV    = 8'h04;

  localparam int CFG_SAFE  = 0;
  localparam int CFG_ABORT = 1;
  localparam int CFG_ALERT = 2;
  localparam int CFG_W     = 3;

  typedef struct packed {
    logic [BYTE_W-1:0] op;
    logic [BYTE_W-1:0] addr;
    logic [BYTE_W-1:0] data;
  } cmd_payload_t;

  function automatic logic [CRC_W-1:0] crc8_calc(
    input logic [PAY_W-1:0] payload,
    input logic [CRC_W-1:0] poly,
    input logic [CRC_W-1:0] init
  );
    logic [CRC_W-1:0] acc;
    logic fb;
    acc = init;
    for (int i = PAY_W - 1; i >= 0; i--) begin
      fb  = acc[CRC_W-1] ^ payload[i];
      acc = {acc[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
    end
    return acc;
  endfunction
endpackage

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import crc_cmd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sck_i,
  input  logic               cs_n_i,
  input  logic               sdi_i,
  input  logic [FRAME_W-1:0] resp_i,
  output logic               sdo_o,
  output logic               frm_evt_o,
  output logic               frm_len_ok_o,
  output logic [FRAME_W-1:0] frm_word_o
);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic sck_q, sck_p, cs_q, cs_p, sdi_q;
  logic [FRAME_W-1:0] rx_sr, tx_sr;
  logic [CNT_W-1:0]   bit_cnt;
  logic sck_rise, sck_fall, cs_fall, cs_rise;

  assign sck_rise = sck_q & ~sck_p;
  assign sck_fall = ~sck_q & sck_p;
  assign cs_fall  = ~cs_q & cs_p;
  assign cs_rise  = cs_q & ~cs_p;
  assign sdo_o    = ~cs_q & tx_sr[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q        <= 1'b0;
      sck_p        <= 1'b0;
      cs_q         <= 1'b1;
      cs_p         <= 1'b1;
      sdi_q        <= 1'b0;
      rx_sr        <= '0;
      tx_sr        <= '0;
      bit_cnt      <= '0;
      frm_evt_o    <= 1'b0;
      frm_len_ok_o <= 1'b0;
      frm_word_o   <= '0;
    end else begin
      sck_q     <= sck_i;
      sck_p     <= sck_q;
      cs_q      <= cs_n_i;
      cs_p      <= cs_q;
      sdi_q     <= sdi_i;
      frm_evt_o <= 1'b0;
      if (cs_fall) begin
        tx_sr   <= resp_i;
        bit_cnt <= '0;
      end else if (!cs_q) begin
        if (sck_rise) begin
          rx_sr <= {rx_sr[FRAME_W-2:0], sdi_q};
          if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
        end
        if (sck_fall) tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
      end
      if (cs_rise) begin
        frm_evt_o    <= 1'b1;
        frm_len_ok_o <= (bit_cnt == CNT_FULL);
        frm_word_o   <= rx_sr;
      end
    end
  end
endmodule

// File: rtl/cmd_exec.sv
module cmd_exec
  import crc_cmd_pkg::*;
#(
  parameter int               NCH      = 8,
  parameter logic [CRC_W-1:0] CRC_POLY = 8'h07,
  parameter logic [CRC_W-1:0] CRC_INIT = 8'hFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frm_evt_i,
  input  logic               frm_len_ok_i,
  input  logic [FRAME_W-1:0] frm_word_i,
  input  logic [BYTE_W-1:0]  conv_data_i,
  output logic [FRAME_W-1:0] resp_o,
  output logic               err_o,
  output logic [CFG_W-1:0]   cfg_o,
  output logic [NCH-1:0]     pinmode_o,
  output logic [NCH-1:0]     outen_o
);
  cmd_payload_t      pl;
  logic [CRC_W-1:0]  rx_crc, calc_crc, rsp_crc;
  logic              eval, crc_ok, wr_ok, do_wr, do_rd;
  logic [BYTE_W-1:0] rd_data;
  logic [PAY_W-1:0]  rsp_pl;

  logic               err_q;
  logic [CFG_W-1:0]   cfg_q;
  logic [NCH-1:0]     pinmode_q, outen_q;
  logic [FRAME_W-1:0] resp_q;

  assign pl       = cmd_payload_t'(frm_word_i[FRAME_W-1:CRC_W]);
  assign rx_crc   = frm_word_i[CRC_W-1:0];
  assign calc_crc = crc8_calc(frm_word_i[FRAME_W-1:CRC_W], CRC_POLY, CRC_INIT);
  assign eval     = frm_evt_i & frm_len_ok_i;
  assign crc_ok   = (calc_crc == rx_crc);
  assign wr_ok    = ~err_q | (pl.addr == ADDR_STATUS) | (pl.addr == ADDR_GENCFG);
  assign do_wr    = eval & crc_ok & (pl.op == OP_WRITE) & wr_ok;
  assign do_rd    = eval & crc_ok & (pl.op == OP_READ);

  always_comb begin
    rd_data = '0;
    unique case (pl.addr)
      ADDR_STATUS:  rd_data = BYTE_W'(err_q);
      ADDR_GENCFG:  rd_data = BYTE_W'(cfg_q);
      ADDR_PINMODE: rd_data = BYTE_W'(pinmode_q);
      ADDR_OUTEN:   rd_data = BYTE_W'(outen_q);
      ADDR_CONV:    rd_data = conv_data_i;
      default:      rd_data = '0;
    endcase
  end

  assign rsp_pl  = {OP_READ, pl.addr, rd_data};
  assign rsp_crc = crc8_calc(rsp_pl, CRC_POLY, CRC_INIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q     <= 1'b0;
      cfg_q     <= '0;
      pinmode_q <= '0;
      outen_q   <= '0;
      resp_q    <= '0;
    end else if (eval) begin
      resp_q <= do_rd ? {rsp_pl, rsp_crc} : '0;
      if (!crc_ok) begin
        err_q <= 1'b1;
      end else if (do_wr) begin
        unique case (pl.addr)
          ADDR_STATUS:  if (pl.data[0]) err_q <= 1'b0;
          ADDR_GENCFG:  cfg_q     <= pl.data[CFG_W-1:0];
          ADDR_PINMODE: pinmode_q <= pl.data[NCH-1:0];
          ADDR_OUTEN:   outen_q   <= pl.data[NCH-1:0];
          default: ;
        endcase
      end
    end
  end

  assign resp_o    = resp_q;
  assign err_o     = err_q;
  assign cfg_o     = cfg_q;
  assign pinmode_o = pinmode_q;
  assign outen_o   = outen_q;

  assert_err_needs_bad_crc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(frm_evt_i && frm_len_ok_i && !crc_ok));

  assert_locked_pins_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> ($stable(pinmode_q) && $stable(outen_q)));

  assert_clear_needs_status_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_q) |-> $past(frm_evt_i && frm_len_ok_i && crc_ok && pl.op == OP_WRITE
                           && pl.addr == ADDR_STATUS && pl.data[0]));

  assert_bad_frame_no_resp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_evt_i && frm_len_ok_i && !crc_ok) |=> resp_q == '0);

  assert_short_frame_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_evt_i && !frm_len_ok_i) |=> ($stable(err_q) && $stable(cfg_q)
                                      && $stable(pinmode_q) && $stable(resp_q)));
endmodule

// File: rtl/crc_cmd_if.sv
module crc_cmd_if
  import crc_cmd_pkg::*;
#(
  parameter int               NCH      = 8,
  parameter logic [CRC_W-1:0] CRC_POLY = 8'h07,
  parameter logic [CRC_W-1:0] CRC_INIT = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck_i,
  input  logic              spi_cs_n_i,
  input  logic              spi_sdi_i,
  output logic              spi_sdo_o,
  input  logic [BYTE_W-1:0] conv_data_i,
  output logic [NCH-1:0]    chan_digital_o,
  output logic [NCH-1:0]    chan_drive_o,
  output logic              crc_err_o,
  output logic              alert_o,
  output logic              conv_abort_o
);
  logic               frm_evt, frm_len_ok, err, force_safe;
  logic [FRAME_W-1:0] frm_word, resp;
  logic [CFG_W-1:0]   cfg;
  logic [NCH-1:0]     pinmode, outen;

  spi_frame_rx u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .sck_i        (spi_sck_i),
    .cs_n_i       (spi_cs_n_i),
    .sdi_i        (spi_sdi_i),
    .resp_i       (resp),
    .sdo_o        (spi_sdo_o),
    .frm_evt_o    (frm_evt),
    .frm_len_ok_o (frm_len_ok),
    .frm_word_o   (frm_word)
  );

  cmd_exec #(
    .NCH      (NCH),
    .CRC_POLY (CRC_POLY),
    .CRC_INIT (CRC_INIT)
  ) u_exec (
    .clk          (clk),
    .rst_n        (rst_n),
    .frm_evt_i    (frm_evt),
    .frm_len_ok_i (frm_len_ok),
    .frm_word_i   (frm_word),
    .conv_data_i  (conv_data_i),
    .resp_o       (resp),
    .err_o        (err),
    .cfg_o        (cfg),
    .pinmode_o    (pinmode),
    .outen_o      (outen)
  );

  assign force_safe     = err & cfg[CFG_SAFE];
  assign chan_digital_o = force_safe ? '0 : pinmode;
  assign chan_drive_o   = force_safe ? '0 : (pinmode & outen);
  assign crc_err_o      = err;
  assign alert_o        = err & cfg[CFG_ALERT];
  assign conv_abort_o   = err & cfg[CFG_ABORT];

  assert_drive_only_digital_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_drive_o & ~chan_digital_o) == '0);
endmodule

// File: tb/crc_cmd_if_tb.sv
module crc_cmd_if_tb;
  localparam logic [7:0] RD = 8'h08, WR = 8'h10;
  localparam logic [7:0] A_ST = 8'h00, A_CFG = 8'h01, A_PIN = 8'h02, A_OE = 8'h03, A_CNV = 8'h04;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic [7:0] conv = 8'h5A;
  logic sdo, err, alert, abrt;
  logic [7:0] dig, drv;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$], got_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  crc_cmd_if u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sck_i(sck), .spi_cs_n_i(cs_n), .spi_sdi_i(sdi),
    .spi_sdo_o(sdo), .conv_data_i(conv), .chan_digital_o(dig), .chan_drive_o(drv),
    .crc_err_o(err), .alert_o(alert), .conv_abort_o(abrt)
  );

  function automatic logic [7:0] ref_crc(input logic [23:0] p);
    logic [7:0] c = 8'hFF;
    for (int i = 23; i >= 0; i--) begin
      if (c[7] ^ p[i]) c = (c << 1) ^ 8'h07;
      else             c = c << 1;
    end
    return c;
  endfunction

  function automatic logic [31:0] mk(input logic [7:0] op, a, d);
    return {op, a, d, ref_crc({op, a, d})};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic outs(input string req, input logic [7:0] e_dig, e_drv,
                      input bit e_err, e_alert, e_abort);
    chk(dig == e_dig, {req, " chan_digital"}, 32'(dig), 32'(e_dig));
    chk(drv == e_drv, {req, " chan_drive"}, 32'(drv), 32'(e_drv));
    chk(err == e_err, {req, " crc_err"}, 32'(err), 32'(e_err));
    chk(alert == e_alert, {req, " alert"}, 32'(alert), 32'(e_alert));
    chk(abrt == e_abort, {req, " abort"}, 32'(abrt), 32'(e_abort));
  endtask

  task automatic shift(input logic [31:0] w, input int nbits);
    logic [31:0] cap = '0;
    @(negedge clk); cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 32) ? w[31-i] : 1'b0;
      repeat (4) @(negedge clk);
      cap = {cap[30:0], sdo};
      sck = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
    if (nbits == 32) got_q.push_back(cap);
  endtask

  task automatic wr(input logic [7:0] a, d, input bit bad = 1'b0);
    logic [31:0] w = mk(WR, a, d);
    if (bad) w[0] = ~w[0];
    shift(w, 32);
    exp_q.push_back('0);
    tag_q.push_back("R5 after write");
  endtask

  task automatic rd(input logic [7:0] a, d, input string req, input bit bad = 1'b0);
    logic [31:0] w = mk(RD, a, d);
    if (bad) w[0] = ~w[0];
    w[15:8] = 8'h00;
    w[7:0]  = ref_crc(w[31:8]) ^ {7'b0, bad};
    shift(w, 32);
    exp_q.push_back(bad ? 32'h0 : mk(RD, a, d));
    tag_q.push_back(req);
  endtask

  initial begin : monitor
    logic [31:0] g, e;
    string t;
    forever begin
      wait (got_q.size() > 0);
      g = got_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(g == e, t, g, e);
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10: reset state
    outs("R10", 8'h00, 8'h00, 0, 0, 0);
    chk(sdo == 1'b0, "R10 sdo", 32'(sdo), 0);
    exp_q.push_back('0); tag_q.push_back("R10 first response");

    wr(A_PIN, 8'hF0);
    wr(A_OE, 8'h3C);
    outs("R11", 8'hF0, 8'h30, 0, 0, 0);
    rd(A_PIN, 8'hF0, "R5 read pinmode");
    rd(A_OE, 8'h3C, "R5 read outen");
    wr(A_CFG, 8'h00);
    rd(A_ST, 8'h00, "R5 read status");

    // R9: 16-clock and 33-clock frames are discarded
    shift(mk(WR, A_PIN, 8'h00), 16);
    outs("R9 short", 8'hF0, 8'h30, 0, 0, 0);
    shift({mk(WR, A_PIN, 8'h00)}, 33);
    outs("R9 long", 8'hF0, 8'h30, 0, 0, 0);

    wr(A_CFG, 8'h07);
    outs("R6 armed", 8'hF0, 8'h30, 0, 0, 0);
    wr(A_PIN, 8'h00, 1'b1);
    outs("R1 R6 R7 R8 bad crc", 8'h00, 8'h00, 1, 1, 1);

    wr(A_PIN, 8'h0F);
    wr(A_OE, 8'hFF);
    rd(A_PIN, 8'hF0, "R2 R4 pinmode blocked");
    rd(A_OE, 8'h3C, "R2 R4 outen blocked");
    rd(A_CNV, 8'h5A, "R12 R4 conv read");
    rd(A_ST, 8'h01, "R1 R4 status read");

    wr(A_CFG, 8'h00);
    outs("R3 R6 cfg write in lock", 8'hF0, 8'h30, 1, 0, 0);
    wr(A_CFG, 8'h07);
    outs("R6 R7 R8 re-armed", 8'h00, 8'h00, 1, 1, 1);
    wr(A_ST, 8'h00);
    outs("R3 status bit0 clear", 8'h00, 8'h00, 1, 1, 1);
    wr(A_ST, 8'h01, 1'b1);
    outs("R3 bad crc clear", 8'h00, 8'h00, 1, 1, 1);
    wr(A_ST, 8'h01);
    outs("R3 R6 cleared", 8'hF0, 8'h30, 0, 0, 0);

    wr(A_PIN, 8'h0F);
    outs("R2 unlocked write", 8'h0F, 8'h0C, 0, 0, 0);

    wr(A_CFG, 8'h00);
    rd(A_PIN, 8'h0F, "R5 bad read gives zero", 1'b1);
    outs("R6 R7 R8 disabled", 8'h0F, 8'h0C, 1, 0, 0);
    rd(A_CFG, 8'h00, "R4 cfg read");
    wr(A_ST, 8'h01);
    outs("R3 final clear", 8'h0F, 8'h0C, 0, 0, 0);

    repeat (10) @(negedge clk);
    wait (got_q.size() == 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule